// File: doc/BRIEF.md
# Shared-Pin Test Access Port

This block is a boundary-scan test access port whose pins are also the pins of a serial background-debug interface. A static select input decides which function owns the pins. With select high the block runs the standard sixteen-state TAP controller on the test clock. It holds a 4-bit instruction register, a one-cell bypass register and a boundary-scan chain. The chain covers a parameterised set of system output pins (driven by the core) and system input pins (read by the core). With select low the mode-select, data-in and test-reset pins are passed to a debug-port interface. The debug engine's serial output drives the data-out pin. The TAP is held in reset for as long as the debug side owns the pins.

Three instructions are decoded. SAMPLE captures the live pin values and shifts them out while the pins keep working normally. EXTEST drives the pads from the chain's update stage. The bypass instruction shortens the scan path to one cell and also parks every controlled output in a safe value set by a parameter. Any other opcode selects the bypass cell and leaves the pins functional.

Top module: `tap_debug_mux`

## Requirements
- R1: With `pin_sel`=0, `dbg_bkpt`, `dbg_dsi` and `dbg_dsclk` follow `pin_tms`, `pin_tdi` and `pin_trst_n`. `pin_tdo` equals `dbg_dso` with `pin_tdo_oe`=1, and `pad_out` follows `core_out`. With `pin_sel`=1 the three debug outputs are 0.
- R2: The controller follows the sixteen-state TAP graph on rising `pin_tck`. Five consecutive rising edges with `pin_tms`=1 bring it to Test-Logic-Reset from any state.
- R3: The TAP is reset asynchronously whenever `pin_trst_n`=0 or `pin_sel`=0. Reset is released after two rising `pin_tck` edges with both inputs high.
- R4: In reset and in Test-Logic-Reset the active instruction is bypass (4'b1111). After reset `pin_tdo_oe`=0 and `pad_out` equals `SAFE_OUT`.
- R5: Capture-IR loads 4'b0001 into the instruction shift stage. The instruction is shifted least significant bit first. A new opcode becomes active only on the edge that leaves Update-IR.
- R6: `pin_tdo` and `pin_tdo_oe` change only on falling `pin_tck`. `pin_tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR.
- R7: For bypass and for every opcode other than 4'b0000 and 4'b0010, the data path is a single cell that captures 0. Data on `pin_tdi` then appears on `pin_tdo` one shift later.
- R8: While bypass (4'b1111) is active and `pin_sel`=1, `pad_out` equals `SAFE_OUT`. Unassigned opcodes leave `pad_out` equal to `core_out`.
- R9: SAMPLE (4'b0010) captures `{pad_out, pad_in}` at Capture-DR, with the input pins in the low `NUM_IN` bits. The chain is shifted least significant bit first, and `pad_out` and `core_in` stay functional.
- R10: The chain update stage loads at the edge leaving Update-DR under SAMPLE or EXTEST. Under EXTEST (4'b0000), `pad_out` takes the update stage's upper bits and `core_in` its lower `NUM_IN` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pin_sel | input | 1 | Owner select: 1 test port, 0 debug interface |
| pin_tck | input | 1 | Test clock |
| pin_tms | input | 1 | Mode select / breakpoint |
| pin_tdi | input | 1 | Test data in / debug serial in |
| pin_trst_n | input | 1 | Test reset, active low / debug serial clock |
| pin_tdo | output | 1 | Test data out / debug serial out |
| pin_tdo_oe | output | 1 | Output enable for the data-out pad |
| dbg_bkpt | output | 1 | Breakpoint to debug engine |
| dbg_dsi | output | 1 | Serial data to debug engine |
| dbg_dsclk | output | 1 | Serial clock to debug engine |
| dbg_dso | input | 1 | Serial data from debug engine |
| core_out | input | NUM_OUT | Functional values for the controlled outputs |
| pad_out | output | NUM_OUT | Values driven to the output pads |
| pad_in | input | NUM_IN | Values read from the input pads |
| core_in | output | NUM_IN | Input values delivered to the core |

## Verification
The clocked properties assume that `pin_sel` is static while the test clock runs. They also assume that `pin_tms` and `pin_tdi` are stable around each rising edge, so that the sampled controller state is the one the data path acts on. The stimulus changes `pin_tms` and `pin_tdi` one nanosecond after each falling edge. It flips `pin_sel` only when the controller is idle or in reset. The bench re-enters Test-Logic-Reset with five mode-select-high cycles after every change of owner.

// File: rtl/tapdbg_pkg.sv
`timescale 1ns/1ps
package tapdbg_pkg;

  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE = 4'b0010;
  localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-2){1'b0}}, 2'b01};

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
  import tapdbg_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TLR:    state_d = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state_q <= ST_TLR;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R2: five rising edges with mode select high always end in Test-Logic-Reset
  a_r2_five_tms_reset: assert property (@(posedge tck) disable iff (!rst_n)
    ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
    |-> (state_q == ST_TLR));

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
  import tapdbg_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir,
  output logic            ir_so
);

  logic [IR_W-1:0] sr_q, sr_d;
  logic            sr_en;
  logic [IR_W-1:0] ir_q, ir_d;
  logic            ir_en;

  always_comb begin
    sr_en = 1'b0;
    sr_d  = sr_q;
    if (state == ST_CAP_IR) begin
      sr_en = 1'b1;
      sr_d  = IR_CAPTURE;
    end else if (state == ST_SH_IR) begin
      sr_en = 1'b1;
      sr_d  = {tdi, sr_q[IR_W-1:1]};
    end
  end

  always_comb begin
    ir_en = 1'b0;
    ir_d  = ir_q;
    if (state == ST_TLR) begin
      ir_en = 1'b1;
      ir_d  = OP_BYPASS;
    end else if (state == ST_UPD_IR) begin
      ir_en = 1'b1;
      ir_d  = sr_q;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= IR_CAPTURE;
      ir_q <= OP_BYPASS;
    end else begin
      if (sr_en) sr_q <= sr_d;
      if (ir_en) ir_q <= ir_d;
    end
  end

  assign ir    = ir_q;
  assign ir_so = sr_q[0];

  // R5: capture loads the fixed 01 pattern in the low bits
  a_r5_capture_pattern: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_IR) |=> (sr_q[1:0] == 2'b01));

  // R4: Test-Logic-Reset selects bypass
  a_r4_tlr_bypass: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_TLR) |=> (ir_q == OP_BYPASS));

endmodule

// File: rtl/tap_bsr.sv
`timescale 1ns/1ps
module tap_bsr
  import tapdbg_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4,
  localparam int LEN    = NUM_IN + NUM_OUT
) (
  input  logic           tck,
  input  logic           rst_n,
  input  tap_state_e     state,
  input  logic           tdi,
  input  logic           chain_en,
  input  logic [LEN-1:0] cap_val,
  output logic [LEN-1:0] sr_q,
  output logic [LEN-1:0] upd_q
);

  logic cap_en, sh_en, up_en;

  always_comb begin
    cap_en = chain_en && (state == ST_CAP_DR);
    sh_en  = chain_en && (state == ST_SH_DR);
    up_en  = chain_en && (state == ST_UPD_DR);
  end

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    logic ser_in;
    logic sr_d;

    if (i == LEN - 1) begin : g_head
      assign ser_in = tdi;
    end else begin : g_body
      assign ser_in = sr_q[i+1];
    end

    always_comb begin
      sr_d = sr_q[i];
      if (cap_en)     sr_d = cap_val[i];
      else if (sh_en) sr_d = ser_in;
    end

    always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
        sr_q[i]  <= 1'b0;
        upd_q[i] <= 1'b0;
      end else begin
        if (cap_en || sh_en) sr_q[i] <= sr_d;
        if (up_en)           upd_q[i] <= sr_q[i];
      end
    end
  end

endmodule

// File: rtl/tap_debug_mux.sv
`timescale 1ns/1ps
module tap_debug_mux
  import tapdbg_pkg::*;
#(
  parameter int                 NUM_IN   = 4,
  parameter int                 NUM_OUT  = 4,
  parameter logic [NUM_OUT-1:0] SAFE_OUT = 4'b0101
) (
  input  logic               pin_sel,
  input  logic               pin_tck,
  input  logic               pin_tms,
  input  logic               pin_tdi,
  input  logic               pin_trst_n,
  output logic               pin_tdo,
  output logic               pin_tdo_oe,
  output logic               dbg_bkpt,
  output logic               dbg_dsi,
  output logic               dbg_dsclk,
  input  logic               dbg_dso,
  input  logic [NUM_OUT-1:0] core_out,
  output logic [NUM_OUT-1:0] pad_out,
  input  logic [NUM_IN-1:0]  pad_in,
  output logic [NUM_IN-1:0]  core_in
);

  localparam int LEN = NUM_IN + NUM_OUT;

  // reset: asserted at once, released on the second rising test clock
  logic       raw_rst_n;
  logic [1:0] rst_sync_q;
  logic       tap_rst_n;

  assign raw_rst_n = pin_sel & pin_trst_n;

  always_ff @(posedge pin_tck or negedge raw_rst_n) begin
    if (!raw_rst_n) rst_sync_q <= 2'b00;
    else            rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign tap_rst_n = rst_sync_q[1];

  tap_state_e      state;
  logic [IR_W-1:0] ir;
  logic            ir_so;
  logic [LEN-1:0]  bsr_sr, bsr_upd;
  logic [LEN-1:0]  cap_val;
  logic            chain_en, byp_en;
  logic            is_extest, is_safe;

  tap_fsm u_fsm (
    .tck   (pin_tck),
    .rst_n (tap_rst_n),
    .tms   (pin_tms),
    .state (state)
  );

  tap_ir u_ir (
    .tck   (pin_tck),
    .rst_n (tap_rst_n),
    .state (state),
    .tdi   (pin_tdi),
    .ir    (ir),
    .ir_so (ir_so)
  );

  always_comb begin
    chain_en  = (ir == OP_EXTEST) || (ir == OP_SAMPLE);
    byp_en    = !chain_en;
    is_extest = pin_sel && (ir == OP_EXTEST);
    is_safe   = pin_sel && (ir == OP_BYPASS);
  end

  tap_bsr #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_bsr (
    .tck      (pin_tck),
    .rst_n    (tap_rst_n),
    .state    (state),
    .tdi      (pin_tdi),
    .chain_en (chain_en),
    .cap_val  (cap_val),
    .sr_q     (bsr_sr),
    .upd_q    (bsr_upd)
  );

  // pad steering
  always_comb begin
    if (is_extest)    pad_out = bsr_upd[LEN-1:NUM_IN];
    else if (is_safe) pad_out = SAFE_OUT;
    else              pad_out = core_out;
    core_in = is_extest ? bsr_upd[NUM_IN-1:0] : pad_in;
    cap_val = {pad_out, pad_in};
  end

  // single-cell bypass register
  logic byp_q, byp_d, byp_en_q;

  always_comb begin
    byp_en_q = 1'b0;
    byp_d    = byp_q;
    if (byp_en && state == ST_CAP_DR) begin
      byp_en_q = 1'b1;
      byp_d    = 1'b0;
    end else if (byp_en && state == ST_SH_DR) begin
      byp_en_q = 1'b1;
      byp_d    = pin_tdi;
    end
  end

  always_ff @(posedge pin_tck or negedge tap_rst_n) begin
    if (!tap_rst_n)    byp_q <= 1'b0;
    else if (byp_en_q) byp_q <= byp_d;
  end

  // falling-edge output stage
  logic so_sel, tdo_q, oe_q, oe_d;

  always_comb begin
    if (state == ST_SH_IR) so_sel = ir_so;
    else if (byp_en)       so_sel = byp_q;
    else                   so_sel = bsr_sr[0];
    oe_d = (state == ST_SH_IR) || (state == ST_SH_DR);
  end

  always_ff @(negedge pin_tck or negedge tap_rst_n) begin
    if (!tap_rst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tdo_q <= so_sel;
      oe_q  <= oe_d;
    end
  end

  // pin ownership
  always_comb begin
    pin_tdo    = pin_sel ? tdo_q : dbg_dso;
    pin_tdo_oe = pin_sel ? oe_q  : 1'b1;
    dbg_bkpt   = pin_sel ? 1'b0  : pin_tms;
    dbg_dsi    = pin_sel ? 1'b0  : pin_tdi;
    dbg_dsclk  = pin_sel ? 1'b0  : pin_trst_n;
  end

  // R6: enable seen at a rising edge implies a shift state
  a_r6_oe_only_in_shift: assert property (@(posedge pin_tck) disable iff (!tap_rst_n)
    oe_q |-> (state == ST_SH_DR || state == ST_SH_IR));

  // R7: the bypass cell captures 0
  a_r7_bypass_captures_zero: assert property (@(posedge pin_tck) disable iff (!tap_rst_n)
    (byp_en && state == ST_CAP_DR) |=> (byp_q == 1'b0));

  // R10: after Update-DR under EXTEST the pads carry what was shifted in
  a_r10_extest_drive: assert property (@(posedge pin_tck) disable iff (!tap_rst_n)
    (pin_sel && state == ST_UPD_DR && ir == OP_EXTEST)
    |=> (pad_out == $past(bsr_sr[LEN-1:NUM_IN])));

endmodule

// File: tb/tb_tap_debug_mux.sv
`timescale 1ns/1ps
module tb_tap_debug_mux;

  localparam logic [3:0] SAFE = 4'b0101;
  localparam logic [3:0] OPX  = 4'b0000;
  localparam logic [3:0] OPS  = 4'b0010;
  localparam logic [3:0] OPB  = 4'b1111;

  // {opcode, pad_in, core_out, shift data}
  localparam int NV = 6;
  localparam logic [19:0] VEC [NV] = '{
    {OPS,   4'h3, 4'hA, 8'h5C},
    {OPX,   4'h9, 4'h6, 8'hC3},
    {OPX,   4'h1, 4'hF, 8'h7E},
    {OPB,   4'h6, 4'h2, 8'hB1},
    {4'h5,  4'hC, 4'h9, 8'h2D},
    {OPS,   4'h0, 4'h5, 8'hFF}
  };

  logic tck = 1'b0;
  always #2 tck = ~tck;

  logic       sel, tms, tdi, trst_n, dso;
  logic [3:0] core_out, pad_in;
  wire        tdo, tdo_oe, bkpt, dsi, dsclk;
  wire  [3:0] pad_out, core_in;

  tap_debug_mux dut (
    .pin_sel(sel), .pin_tck(tck), .pin_tms(tms), .pin_tdi(tdi),
    .pin_trst_n(trst_n), .pin_tdo(tdo), .pin_tdo_oe(tdo_oe),
    .dbg_bkpt(bkpt), .dbg_dsi(dsi), .dbg_dsclk(dsclk), .dbg_dso(dso),
    .core_out(core_out), .pad_out(pad_out), .pad_in(pad_in), .core_in(core_in)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic d);
    tms = t;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic tlr_then_idle();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic load_ir(input logic [3:0] op, output logic [3:0] cap, output logic [3:0] pad_mid);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    cap[0] = tdo;
    for (int i = 0; i < 4; i++) begin
      step(i == 3, op[i]);
      if (i < 3) cap[i+1] = tdo;
    end
    step(1, 0);
    pad_mid = pad_out;
    step(0, 0);
  endtask

  task automatic scan_dr(input logic [7:0] din, output logic [7:0] cap);
    step(1, 0); step(0, 0); step(0, 0);
    cap[0] = tdo;
    for (int i = 0; i < 8; i++) begin
      step(i == 7, din[i]);
      if (i < 7) cap[i+1] = tdo;
    end
    step(1, 0);
    step(0, 0);
  endtask

  function automatic logic [3:0] pad_model(input logic [3:0] op, input logic [3:0] core,
                                           input logic [3:0] upd_hi);
    if (op == OPX)      return upd_hi;
    else if (op == OPB) return SAFE;
    else                return core;
  endfunction

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] op, pin, core, ircap, padmid, prev_op, exp_pad;
    logic [7:0] sh, drcap, model_upd, exp_cap;
    logic       chain;

    sel = 1; tms = 1; tdi = 0; trst_n = 0; dso = 0;
    core_out = 4'hA; pad_in = 4'h3;
    repeat (3) @(negedge tck);
    #1;
    check("R4 reset oe", tdo_oe, 0);
    check("R4 reset pads safe", pad_out, SAFE);
    check("R1 debug outs idle in test mode", {bkpt, dsi, dsclk}, 3'b000);

    trst_n = 1;
    tlr_then_idle();

    model_upd = 8'h00;
    prev_op   = OPB;
    for (int v = 0; v < NV; v++) begin
      {op, pin, core, sh} = VEC[v];
      pad_in = pin;
      core_out = core;
      exp_pad = pad_model(prev_op, core, model_upd[7:4]);
      load_ir(op, ircap, padmid);
      check("R5 IR capture pattern", ircap, 4'b0001);
      check("R5 old instruction held in Update-IR", padmid, exp_pad);
      chain = (op == OPX) || (op == OPS);
      exp_pad = pad_model(op, core, model_upd[7:4]);
      exp_cap = chain ? {exp_pad, pin} : {sh[6:0], 1'b0};
      scan_dr(sh, drcap);
      if (chain) check("R9 chain capture", drcap, exp_cap);
      else       check("R7 bypass one-cell path", drcap, exp_cap);
      if (chain) model_upd = sh;
      check("R8 R10 pad drive after scan", pad_out, pad_model(op, core, model_upd[7:4]));
      check("R10 core input source", core_in, (op == OPX) ? model_upd[3:0] : pin);
      prev_op = op;
    end

    // SAMPLE active: five mode-select-high edges restore bypass
    check("R9 sample pads functional", pad_out, core_out);
    for (int i = 0; i < 5; i++) step(1, 0);
    check("R2 five TMS high reach reset", pad_out, SAFE);
    step(0, 0);

    // falling-edge data out, bypass
    step(1, 0); step(0, 0); step(0, 0);
    check("R6 oe in Shift-DR", tdo_oe, 1);
    check("R7 bypass capture bit", tdo, 0);
    tms = 0; tdi = 1;
    @(posedge tck);
    #1;
    check("R6 tdo holds across rising edge", tdo, 0);
    @(negedge tck);
    #1;
    check("R6 tdo moves on falling edge", tdo, 1);
    step(1, 0);
    check("R6 oe off outside shift", tdo_oe, 0);
    step(1, 0); step(0, 0);

    // debug ownership
    load_ir(OPS, ircap, padmid);
    sel = 0; tms = 1; tdi = 0; trst_n = 1; dso = 1; core_out = 4'h9;
    #1;
    check("R1 routing set A", {bkpt, dsi, dsclk}, 3'b101);
    check("R1 tdo from debug", {tdo, tdo_oe}, 2'b11);
    check("R1 pads functional in debug", pad_out, 4'h9);
    tms = 0; tdi = 1; trst_n = 0; dso = 0;
    #1;
    check("R1 routing set B", {bkpt, dsi, dsclk}, 3'b010);
    check("R1 tdo debug zero", {tdo, tdo_oe}, 2'b01);
    trst_n = 1; tms = 1;
    @(negedge tck);
    #1;
    sel = 1;
    #1;
    check("R3 TAP reset while debug owned", pad_out, SAFE);
    check("R3 oe off after return", tdo_oe, 0);
    tlr_then_idle();
    load_ir(OPS, ircap, padmid);
    check("R3 TAP usable after release", ircap, 4'b0001);
    check("R3 sample active after release", pad_out, 4'h9);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule